// File: doc/BRIEF.md
# Multiprocessor Interrupt Mask Controller

This block is the interrupt router for a system of up to four processors. Device interrupt lines are level-sensitive. They pass through a two-flop synchronizer and show up in a read-only system pending register. A system mask gates them before they can request anything. The mask is never written directly. A write-one "disable" strobe sets mask bits, and a write-one "enable" strobe clears them. Bit 31 of the mask is a master switch that blocks every device line at once.

All device (undirected) interrupts are steered to a single target processor, chosen by a read/write register. Each processor also has its own pending register for software and inter-processor interrupts. Any bus master can raise or drop these through write-one set and clear strobes. A level-sensitive profiling-tick input per processor adds a fixed level-14 request for that processor.

For each processor the block computes a registered 4-bit interrupt level. This is the highest level among the requests that reach that processor, and 0 means no request. Several device sources may share one level.

Top module: `irqc_mp_top`

## Requirements
- R1: After reset, every system mask bit reads 1 (the mask word reads 0xFFFFFFFF), the target register reads 0, every per-processor pending register reads 0 and every `cpu_level` field is 0.
- R2: A write to the system disable address (page NCPU, offset 0xC) sets each mask bit whose data bit is 1 and leaves every bit written as 0 unchanged.
- R3: A write to the system enable address (page NCPU, offset 0x8) clears each mask bit whose data bit is 1 and leaves every bit written as 0 unchanged.
- R4: While mask bit 31 is 1, no device line contributes to the level of any processor, whatever the other mask bits hold.
- R5: The system pending word (page NCPU, offset 0x0) shows the synchronized device lines at bits 30:28 and 22:7 and reads 0 at every other bit. A bus write to that address changes neither the pending word nor the mask.
- R6: Processor n's block sits at page n (address n*0x1000). Its pending word is at offset 0x0, its write-one clear at 0x4 and its write-one set at 0x8. The software interrupt for level x is bit 16+x. Bits written as 0 are unaffected.
- R7: Each processor's level is the highest level among its pending software bits (levels 1 to 15; bit 16 requests nothing) and its profiling input. Only the processor named by the target register also includes the highest level among pending, unmasked device lines.
- R8: The device-to-level map is as follows. Slot n (bit n+7, n=0..6) goes to 2, 3, 5, 7, 9, 11, 13. SCSI (bit 18) goes to 4, Ethernet (16) to 6, video (20) to 8, system timer (19) to 10, floppy (22) to 11, serial (15) and keyboard (14) to 12, audio (17) to 13, and module error (30) to 9. Bits 29, 28 and 21 request no level.
- R9: The target register at page NCPU, offset 0x10, holds a processor index in its low bits. It reads back what was written, and a change moves device requests to the new processor.
- R10: Processor n's profiling input, once synchronized, sets bit 14 of its own pending word and requests level 14 for that processor only.
- R11: `cpu_level` is registered. A bus write affects it one clock after the write edge, and a device or profiling input affects it three clocks after it is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 16 | Byte address: page in 15:12, offset in 11:0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational; write-only addresses read 0) |
| dev_irq | input | 32 | Level-sensitive device interrupt lines |
| prof_irq | input | NCPU | Per-processor profiling tick lines |
| cpu_level | output | 4*NCPU | Level for processor n in bits 4n+3:4n |

## Verification
The checker watches the mask and software registers on every cycle. It confirms that each disable, enable or software set/clear write changes exactly the bits written as 1. It also confirms that the master mask bit silences every device request, that a non-target processor never carries a level without a software or profiling request, and that the reset values are correct. The level map, the choice of the highest request when sources share or compete for levels, the pending readback and the target steering can only be shown by the bench. It compares every level and readback against its own model after random mixes of writes and input changes.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    parameter int unsigned WORD_W     = 32;
    parameter int unsigned LVL_W      = 4;
    parameter int unsigned NLVL       = 16;
    parameter int unsigned ADDR_W     = 16;
    parameter int unsigned PAGE_SHIFT = 12;
    parameter int unsigned PAGE_W     = ADDR_W - PAGE_SHIFT;

    // device line positions that exist
    parameter logic [WORD_W-1:0] DEV_VALID = 32'h707F_FF80;
    parameter int unsigned MASK_ALL_BIT = 31;
    parameter int unsigned SOFT_BASE    = 16;
    parameter int unsigned PROF_BIT     = 14;
    parameter logic [LVL_W-1:0] PROF_LVL = 4'd14;

    // offsets inside a processor page
    parameter logic [PAGE_SHIFT-1:0] OFS_CPU_PEND = 12'h000;
    parameter logic [PAGE_SHIFT-1:0] OFS_CPU_CLR  = 12'h004;
    parameter logic [PAGE_SHIFT-1:0] OFS_CPU_SET  = 12'h008;
    // offsets inside the system page
    parameter logic [PAGE_SHIFT-1:0] OFS_SYS_PEND = 12'h000;
    parameter logic [PAGE_SHIFT-1:0] OFS_SYS_MASK = 12'h004;
    parameter logic [PAGE_SHIFT-1:0] OFS_SYS_ENA  = 12'h008;
    parameter logic [PAGE_SHIFT-1:0] OFS_SYS_DIS  = 12'h00C;
    parameter logic [PAGE_SHIFT-1:0] OFS_SYS_TGT  = 12'h010;

    typedef enum logic [2:0] {
        WR_NONE,
        WR_CPU_CLR,
        WR_CPU_SET,
        WR_SYS_ENA,
        WR_SYS_DIS,
        WR_SYS_TGT
    } wr_kind_e;

    typedef struct packed {
        wr_kind_e          kind;
        logic [PAGE_W-1:0] page;
    } wr_dec_t;

    // fixed level of a device line, 0 when the line requests nothing
    function automatic logic [LVL_W-1:0] src_level(input int unsigned b);
        logic [LVL_W-1:0] l;
        case (b)
            7:       l = 4'd2;
            8:       l = 4'd3;
            9:       l = 4'd5;
            10:      l = 4'd7;
            11:      l = 4'd9;
            12:      l = 4'd11;
            13:      l = 4'd13;
            14, 15:  l = 4'd12;
            16:      l = 4'd6;
            17:      l = 4'd13;
            18:      l = 4'd4;
            19:      l = 4'd10;
            20:      l = 4'd8;
            22:      l = 4'd11;
            30:      l = 4'd9;
            default: l = 4'd0;
        endcase
        return l;
    endfunction

    // highest set request among levels 1..15
    function automatic logic [LVL_W-1:0] top_level(input logic [NLVL-1:0] req);
        logic [LVL_W-1:0] r;
        r = '0;
        for (int l = 1; l < NLVL; l++) begin
            if (req[l]) r = LVL_W'(l);
        end
        return r;
    endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/irqc_level_fold.sv
module irqc_level_fold
    import irqc_pkg::*;
(
    input  logic [WORD_W-1:0] enabled,
    output logic [NLVL-1:0]   req
);
    // OR each enabled line into the request bit of its level
    always_comb begin
        req = '0;
        for (int unsigned b = 0; b < WORD_W; b++) begin
            if (DEV_VALID[b] && enabled[b]) req[src_level(b)] = 1'b1;
        end
        req[0] = 1'b0;
    end
endmodule

// File: rtl/irqc_sys_regs.sv
module irqc_sys_regs
    import irqc_pkg::*;
#(
    parameter int unsigned TGT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_kind_e          wr_kind,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] mask_q,
    output logic [TGT_W-1:0]  tgt_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
            tgt_q  <= '0;
        end else begin
            case (wr_kind)
                WR_SYS_DIS: mask_q <= mask_q | wdata;
                WR_SYS_ENA: mask_q <= mask_q & ~wdata;
                WR_SYS_TGT: tgt_q  <= wdata[TGT_W-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/irqc_cpu_port.sv
module irqc_cpu_port
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             set_stb,
    input  logic             clr_stb,
    input  logic [NLVL-1:0]  wbits,
    input  logic             prof,
    input  logic             is_tgt,
    input  logic [NLVL-1:0]  sys_req,
    output logic [NLVL-1:0]  soft_q,
    output logic [LVL_W-1:0] level_q
);
    logic [NLVL-1:0] req;

    always_ff @(posedge clk) begin
        if (rst) begin
            soft_q <= '0;
        end else if (set_stb) begin
            soft_q <= soft_q | wbits;
        end else if (clr_stb) begin
            soft_q <= soft_q & ~wbits;
        end
    end

    always_comb begin
        req = soft_q | (is_tgt ? sys_req : '0);
        req[PROF_LVL] = req[PROF_LVL] | prof;
    end

    always_ff @(posedge clk) begin
        if (rst) level_q <= '0;
        else     level_q <= top_level(req);
    end
endmodule

// File: rtl/irqc_mp_top.sv
module irqc_mp_top
    import irqc_pkg::*;
#(
    parameter int unsigned NCPU = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_we,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [WORD_W-1:0]      bus_wdata,
    output logic [WORD_W-1:0]      bus_rdata,
    input  logic [WORD_W-1:0]      dev_irq,
    input  logic [NCPU-1:0]        prof_irq,
    output logic [NCPU*LVL_W-1:0]  cpu_level
);
    localparam int unsigned TGT_W = (NCPU > 1) ? $clog2(NCPU) : 1;
    localparam logic [PAGE_W-1:0] SYS_PAGE = PAGE_W'(NCPU);

    logic [PAGE_W-1:0]     page;
    logic [PAGE_SHIFT-1:0] ofs;
    wr_dec_t               wdec;
    logic [WORD_W-1:0]     dev_s;
    logic [WORD_W-1:0]     dev_pend;
    logic [NCPU-1:0]       prof_s;
    logic [WORD_W-1:0]     sys_mask;
    logic [TGT_W-1:0]      tgt_sel;
    logic [WORD_W-1:0]     sys_en;
    logic [NLVL-1:0]       sys_req;
    logic [NCPU*NLVL-1:0]  soft_flat;

    assign page = bus_addr[ADDR_W-1:PAGE_SHIFT];
    assign ofs  = bus_addr[PAGE_SHIFT-1:0];

    // write decode
    always_comb begin
        wdec.page = page;
        wdec.kind = WR_NONE;
        if (bus_we) begin
            if (page == SYS_PAGE) begin
                case (ofs)
                    OFS_SYS_ENA: wdec.kind = WR_SYS_ENA;
                    OFS_SYS_DIS: wdec.kind = WR_SYS_DIS;
                    OFS_SYS_TGT: wdec.kind = WR_SYS_TGT;
                    default:     wdec.kind = WR_NONE;
                endcase
            end else if (page < SYS_PAGE) begin
                case (ofs)
                    OFS_CPU_CLR: wdec.kind = WR_CPU_CLR;
                    OFS_CPU_SET: wdec.kind = WR_CPU_SET;
                    default:     wdec.kind = WR_NONE;
                endcase
            end
        end
    end

    irqc_sync #(.W(WORD_W)) u_dev_sync (
        .clk(clk), .rst(rst), .d(dev_irq), .q(dev_s)
    );

    irqc_sync #(.W(NCPU)) u_prof_sync (
        .clk(clk), .rst(rst), .d(prof_irq), .q(prof_s)
    );

    assign dev_pend = dev_s & DEV_VALID;

    irqc_sys_regs #(.TGT_W(TGT_W)) u_sys (
        .clk(clk), .rst(rst), .wr_kind(wdec.kind), .wdata(bus_wdata),
        .mask_q(sys_mask), .tgt_q(tgt_sel)
    );

    assign sys_en = dev_pend & ~sys_mask & {WORD_W{~sys_mask[MASK_ALL_BIT]}};

    irqc_level_fold u_fold (
        .enabled(sys_en), .req(sys_req)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic [NLVL-1:0]  soft_c;
        logic [LVL_W-1:0] lvl_c;

        irqc_cpu_port u_port (
            .clk     (clk),
            .rst     (rst),
            .set_stb (wdec.kind == WR_CPU_SET && wdec.page == PAGE_W'(c)),
            .clr_stb (wdec.kind == WR_CPU_CLR && wdec.page == PAGE_W'(c)),
            .wbits   (bus_wdata[WORD_W-1:SOFT_BASE]),
            .prof    (prof_s[c]),
            .is_tgt  (tgt_sel == TGT_W'(c)),
            .sys_req (sys_req),
            .soft_q  (soft_c),
            .level_q (lvl_c)
        );

        assign soft_flat[c*NLVL +: NLVL]  = soft_c;
        assign cpu_level[c*LVL_W +: LVL_W] = lvl_c;
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (page == SYS_PAGE) begin
            case (ofs)
                OFS_SYS_PEND: bus_rdata = dev_pend;
                OFS_SYS_MASK: bus_rdata = sys_mask;
                OFS_SYS_TGT:  bus_rdata = WORD_W'(tgt_sel);
                default:      bus_rdata = '0;
            endcase
        end else begin
            for (int c = 0; c < NCPU; c++) begin
                if (page == PAGE_W'(c) && ofs == OFS_CPU_PEND) begin
                    bus_rdata[WORD_W-1:SOFT_BASE] = soft_flat[c*NLVL +: NLVL];
                    bus_rdata[PROF_BIT]           = prof_s[c];
                end
            end
        end
    end
endmodule

// File: rtl/irqc_mp_checker.sv
module irqc_mp_checker
    import irqc_pkg::*;
#(
    parameter int unsigned NCPU  = 4,
    parameter int unsigned TGT_W = 2
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  bus_we,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [WORD_W-1:0]     bus_wdata,
    input logic [WORD_W-1:0]     sys_mask,
    input logic [TGT_W-1:0]      tgt_sel,
    input logic [NCPU*NLVL-1:0]  soft_flat,
    input logic [NCPU-1:0]       prof_s,
    input logic [NCPU*LVL_W-1:0] cpu_level
);
    localparam logic [ADDR_W-1:0] SYS_BASE = ADDR_W'(NCPU) << PAGE_SHIFT;

    logic dis_wr, ena_wr;
    assign dis_wr = bus_we && bus_addr == (SYS_BASE | ADDR_W'(OFS_SYS_DIS));
    assign ena_wr = bus_we && bus_addr == (SYS_BASE | ADDR_W'(OFS_SYS_ENA));

    assert_reset_state_R1: assert property (@(posedge clk)
        $fell(rst) |-> (sys_mask == '1 && tgt_sel == '0 && soft_flat == '0 && cpu_level == '0));

    assert_disable_sets_R2: assert property (@(posedge clk) disable iff (rst)
        dis_wr |=> sys_mask == ($past(sys_mask) | $past(bus_wdata)));

    assert_enable_clears_R3: assert property (@(posedge clk) disable iff (rst)
        ena_wr |=> sys_mask == ($past(sys_mask) & ~$past(bus_wdata)));

    assert_mask_all_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(sys_mask[MASK_ALL_BIT]) && $past(soft_flat) == '0 && $past(prof_s) == '0)
        |-> cpu_level == '0);

    for (genvar c = 0; c < NCPU; c++) begin : g_chk
        localparam logic [ADDR_W-1:0] CBASE = ADDR_W'(c) << PAGE_SHIFT;

        assert_soft_set_R6: assert property (@(posedge clk) disable iff (rst)
            (bus_we && bus_addr == (CBASE | ADDR_W'(OFS_CPU_SET)))
            |=> soft_flat[c*NLVL +: NLVL] ==
                ($past(soft_flat[c*NLVL +: NLVL]) | $past(bus_wdata[WORD_W-1:SOFT_BASE])));

        assert_soft_clear_R6: assert property (@(posedge clk) disable iff (rst)
            (bus_we && bus_addr == (CBASE | ADDR_W'(OFS_CPU_CLR)))
            |=> soft_flat[c*NLVL +: NLVL] ==
                ($past(soft_flat[c*NLVL +: NLVL]) & ~$past(bus_wdata[WORD_W-1:SOFT_BASE])));

        assert_nontarget_quiet_R7: assert property (@(posedge clk) disable iff (rst)
            ($past(tgt_sel) != TGT_W'(c) && $past(soft_flat[c*NLVL +: NLVL]) == '0
             && !$past(prof_s[c]))
            |-> cpu_level[c*LVL_W +: LVL_W] == '0);
    end
endmodule

bind irqc_mp_top irqc_mp_checker #(.NCPU(NCPU), .TGT_W(TGT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .sys_mask  (sys_mask),
    .tgt_sel   (tgt_sel),
    .soft_flat (soft_flat),
    .prof_s    (prof_s),
    .cpu_level (cpu_level)
);

// File: tb/irqc_mp_top_test.sv
module irqc_mp_top_test;
    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] dev_irq = '0;
    logic [NC-1:0]   prof_irq = '0;
    logic [NC*4-1:0] cpu_level;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    logic [31:0] m_mask;
    logic [31:0] m_soft [NC];
    int          m_tgt;

    always #2 clk = ~clk;

    irqc_mp_top #(.NCPU(NC)) uut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_irq(dev_irq),
        .prof_irq(prof_irq), .cpu_level(cpu_level)
    );

    localparam logic [15:0] SYS = 16'h4000;

    function automatic int lvl_of(int b);
        if (b >= 7 && b <= 13) begin
            int slot_l [7] = '{2, 3, 5, 7, 9, 11, 13};
            return slot_l[b-7];
        end
        if (b == 18) return 4;
        if (b == 16) return 6;
        if (b == 20) return 8;
        if (b == 19) return 10;
        if (b == 22) return 11;
        if (b == 14 || b == 15) return 12;
        if (b == 17) return 13;
        if (b == 30) return 9;
        return 0;
    endfunction

    function automatic int exp_level(int c);
        int best = 0;
        for (int x = 1; x < 16; x++)
            if (m_soft[c][16+x] && x > best) best = x;
        if (prof_irq[c] && best < 14) best = 14;
        if (m_tgt == c && !m_mask[31]) begin
            for (int b = 0; b < 31; b++)
                if (dev_irq[b] && !m_mask[b] && lvl_of(b) > best) best = lvl_of(b);
        end
        return best;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [15:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        if (a == SYS + 16'h00C) m_mask = m_mask | d;
        if (a == SYS + 16'h008) m_mask = m_mask & ~d;
        if (a == SYS + 16'h010) m_tgt = int'(d[1:0]);
        for (int c = 0; c < NC; c++) begin
            if (a == 16'(c * 4096 + 8)) m_soft[c] = m_soft[c] | (d & 32'hFFFF_0000);
            if (a == 16'(c * 4096 + 4)) m_soft[c] = m_soft[c] & ~(d & 32'hFFFF_0000);
        end
    endtask

    task automatic rd_check(string req, logic [15:0] a, logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic levels_check(string req);
        repeat (4) @(negedge clk);
        for (int c = 0; c < NC; c++)
            check(req, 32'(cpu_level[c*4 +: 4]), 32'(exp_level(c)));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        int seed;
        logic [31:0] r;
        seed = 5;
        r = $urandom(seed);
        m_mask = '1; m_tgt = 0;
        for (int c = 0; c < NC; c++) m_soft[c] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_check("R1 mask", SYS + 16'h004, 32'hFFFF_FFFF);
        rd_check("R1 target", SYS + 16'h010, 32'h0);
        for (int c = 0; c < NC; c++) rd_check("R1 cpu pending", 16'(c * 4096), 32'h0);
        check("R1 levels", 32'(cpu_level), 32'h0);

        // R5 pending readback, non-existent bits read 0
        dev_irq = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        rd_check("R5 pending", SYS, 32'h707F_FF80);
        wr(SYS, 32'h0);
        rd_check("R5 pending write ignored", SYS, 32'h707F_FF80);
        rd_check("R5 mask untouched", SYS + 16'h004, 32'hFFFF_FFFF);
        levels_check("R4 mask all at reset");

        // R3 unmask all but mask-all: still silent (R4)
        wr(SYS + 16'h008, 32'h7FFF_FFFF);
        rd_check("R3 enable", SYS + 16'h004, 32'h8000_0000);
        levels_check("R4 mask-all blocks");
        // drop mask-all: highest device level is 13 on cpu 0
        wr(SYS + 16'h008, 32'h8000_0000);
        levels_check("R7 target gets devices");
        check("R8 top level", 32'(cpu_level[3:0]), 32'd13);

        // R8 single sources
        for (int b = 7; b < 31; b++) begin
            if (lvl_of(b) != 0) begin
                dev_irq = 32'h1 << b;
                levels_check("R8 single source level");
            end
        end
        // R8 lines that request nothing
        dev_irq = 32'h3020_0000;
        levels_check("R8 unmapped lines");

        // R9 steering
        dev_irq = 32'h0008_0000;
        wr(SYS + 16'h010, 32'h2);
        rd_check("R9 target readback", SYS + 16'h010, 32'h2);
        levels_check("R9 steer to cpu2");
        check("R9 cpu2 timer", 32'(cpu_level[11:8]), 32'd10);

        // R2 disable with zeros leaves others
        wr(SYS + 16'h00C, 32'h0008_0000);
        rd_check("R2 disable", SYS + 16'h004, 32'h0008_0000);
        levels_check("R2 masked source silent");

        // R6 soft interrupt on cpu 3, level 15, and bit16 requests nothing
        wr(16'h3008, 32'h8001_0000);
        rd_check("R6 soft pending", 16'h3000, 32'h8001_0000);
        levels_check("R6 soft level");
        check("R6 level 15", 32'(cpu_level[15:12]), 32'd15);
        wr(16'h3004, 32'h8000_0000);
        rd_check("R6 soft clear", 16'h3000, 32'h0001_0000);
        levels_check("R6 bit16 no level");

        // R10 profiling tick
        prof_irq = 4'b0010;
        repeat (3) @(negedge clk);
        rd_check("R10 prof pending", 16'h1000, 32'h0000_4000);
        levels_check("R10 prof level");
        prof_irq = '0;

        // random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom_range(0, 5));
            r = $urandom;
            case (op)
                0: wr(SYS + 16'h00C, r & ($urandom_range(0, 3) == 0 ? 32'hFFFF_FFFF : 32'h7FFF_FFFF));
                1: wr(SYS + 16'h008, r);
                2: wr(16'($urandom_range(0, NC - 1) * 4096 + 8), r);
                3: wr(16'($urandom_range(0, NC - 1) * 4096 + 4), r);
                4: wr(SYS + 16'h010, r);
                default: begin
                    dev_irq = $urandom;
                    prof_irq = 4'($urandom);
                end
            endcase
            levels_check("R7 random levels");
            rd_check("R2 R3 mask random", SYS + 16'h004, m_mask);
            rd_check("R11 pending random", SYS, dev_irq & 32'h707F_FF80);
        end

        // R11 latency: write affects level one clock after the write edge
        wr(SYS + 16'h010, 32'h0);
        for (int c = 0; c < NC; c++) wr(16'(c * 4096 + 4), 32'hFFFF_0000);
        dev_irq = '0; prof_irq = '0;
        levels_check("R11 quiet");
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 16'h0008; bus_wdata = 32'h0010_0000;
        @(posedge clk);
        #1;
        bus_we = 1'b0;
        check("R11 not yet", 32'(cpu_level[3:0]), 32'd0);
        @(posedge clk);
        #1;
        check("R11 one clock", 32'(cpu_level[3:0]), 32'd4);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule